// File: doc/BRIEF.md
# Variable Page Size TLB Lookup

This block is a fully associative translation buffer for a 64-bit virtual address space. Each slot maps one page of 8 KB, 64 KB, 512 KB or 4 MB onto a 41-bit physical address and carries a 13-bit context tag. Every slot is compared in parallel against the requested virtual page under its own size mask. A lookup serves either a data access (load, store or no-fault load) or an instruction fetch. It returns the physical page number and the granted permissions, or a trap code.

A fault or miss also updates the translation-state registers kept for software. The data side has a status word, a fault address and a tag-access word. The fetch side has a status word and a tag-access word. Miss handling and choice of the slot to refill belong to software, which writes slots through the fill port. Each slot's used flag is visible on a port.

Top module: `vtlb_lookup`

## Requirements
- R1: A request held on `req_valid` during one rising edge produces `rsp_valid` high one cycle later, with trap, page and permission outputs valid in that same cycle. After a synchronous reset every output reads zero.
- R2: `fill_attr[3:2]` holds the size code s (0..3), giving a page of 8 KB shifted left by 3*s. The low 3*s bits of the virtual page number take no part in the compare. They pass straight into the returned physical page number; the upper bits come from the slot.
- R3: A slot hits only when `fill_attr[0]` (valid) was set, the virtual page matches under its mask, and either `fill_attr[1]` (global) was set or its stored context equals the selected context.
- R4: When several slots hit, the one with the lowest index supplies the result.
- R5: The data context is `ctx_primary` for `req_space`=0, `ctx_secondary` for 1, and zero for 2 (nucleus). A fetch uses `ctx_primary` when `tl_zero` is high and zero otherwise.
- R6: A data hit faults with `rsp_trap`=3 when any of these holds: a user access to a slot with `fill_attr[4]` (privileged), which sets status bit 6; a no-fault load (`req_op`=2) to a slot with `fill_attr[6]` (side effect), which sets bit 7; an ordinary load or store to a slot with `fill_attr[7]` (no-fault only), which sets bit 8. Several of these bits may be set together.
- R7: A store (`req_op`=1) to a slot without `fill_attr[5]` (writable) that has no R6 fault gives `rsp_trap`=4. It records status with no fault-type bit set.
- R8: On trap 3 or 4, `d_status` takes the following bits. Bit 0 is valid. Bit 1 is overflow, set when bit 0 was already set. Bit 2 marks a store, bit 3 copies `cpu_priv`, and bits 5:4 give the context class (0 primary, 1 secondary, 2 nucleus). Bit 9 marks a no-fault load, and bits 6..8 are the fault types. `d_fault_va` takes the page-aligned VA and `d_tag_access` takes {VA[63:13], context}.
- R9: A data miss gives `rsp_trap`=1 and a fetch miss gives 2. Only the matching tag-access register changes, to {VA[63:13], context}. Any trap returns zero page and zero permissions.
- R10: A hit without a trap sets that slot's `used_flags` bit. A data hit grants `rsp_perm` read (bit 0), plus write (bit 1) when the slot is writable. A trapped access leaves used flags unchanged.
- R11: A fetch hit grants execute only (`rsp_perm`=3'b100). A user fetch to a privileged slot gives `rsp_trap`=5. `i_status` then takes bit 0 valid, bit 1 overflow, bit 3 `cpu_priv`, bits 5:4 equal to 2 when `tl_zero` is low, and bit 6. `i_tag_access` is also written.
- R12: Filling a slot clears its used flag. `d_status_clr` and `i_status_clr` zero their status word at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_en | input | 1 | Write a slot |
| fill_idx | input | 6 | Slot index to write |
| fill_vpn | input | 51 | Virtual page number tag |
| fill_ctx | input | 13 | Context tag |
| fill_ppn | input | 28 | Physical page number |
| fill_attr | input | 8 | 0 valid, 1 global, 3:2 size, 4 privileged, 5 writable, 6 side effect, 7 no-fault only |
| req_valid | input | 1 | Lookup request |
| req_fetch | input | 1 | Instruction fetch when high |
| req_op | input | 2 | Data op: 0 load, 1 store, 2 no-fault load |
| req_space | input | 2 | Data context: 0 primary, 1 secondary, 2 nucleus |
| req_user | input | 1 | Access made in user mode |
| cpu_priv | input | 1 | Processor privileged mode, recorded in status |
| tl_zero | input | 1 | Trap level is zero |
| ctx_primary | input | 13 | Primary context |
| ctx_secondary | input | 13 | Secondary context |
| req_va | input | 64 | Virtual address |
| d_status_clr | input | 1 | Clear data status word |
| i_status_clr | input | 1 | Clear fetch status word |
| rsp_valid | output | 1 | Result valid |
| rsp_trap | output | 3 | 0 none, 1 data miss, 2 fetch miss, 3 data fault, 4 data protection, 5 fetch fault |
| rsp_ppn | output | 28 | Physical address bits 40:13 |
| rsp_perm | output | 3 | Bit 0 read, 1 write, 2 execute |
| used_flags | output | 64 | Per-slot used flag |
| d_status | output | 10 | Data fault status |
| d_fault_va | output | 64 | Data fault address |
| d_tag_access | output | 64 | Data tag-access word |
| i_status | output | 10 | Fetch fault status |
| i_tag_access | output | 64 | Fetch tag-access word |

## Verification
Every result of a lookup lands at the first rising edge after the request is presented. This covers the response outputs, the used flag, and all five state registers. A fill or a status clear also takes effect at the next edge. The bench therefore drives each stimulus just after a falling edge and removes it at the following falling edge. It samples all outputs at that falling edge, half a cycle after the register update and before any later stimulus can disturb them.

// File: rtl/vtlb_pkg.sv
// Shared types and field positions for the variable page size TLB lookup.
// Assumes the size code is 2 bits and the status word is 10 bits wide.
package vtlb_pkg;

    typedef enum logic [2:0] {
        TRAP_NONE   = 3'd0,
        TRAP_DMISS  = 3'd1,
        TRAP_IMISS  = 3'd2,
        TRAP_DFAULT = 3'd3,
        TRAP_DPROT  = 3'd4,
        TRAP_IFAULT = 3'd5
    } trap_e;

    localparam logic [1:0] OP_LOAD    = 2'd0;
    localparam logic [1:0] OP_STORE   = 2'd1;
    localparam logic [1:0] OP_NOFAULT = 2'd2;

    localparam logic [1:0] SPACE_PRI = 2'd0;
    localparam logic [1:0] SPACE_SEC = 2'd1;
    localparam logic [1:0] SPACE_NUC = 2'd2;

    localparam int STATUS_W   = 10;
    localparam int ST_VALID   = 0;
    localparam int ST_OVF     = 1;
    localparam int ST_WRITE   = 2;
    localparam int ST_PRIV    = 3;
    localparam int ST_CTX_LO  = 4;
    localparam int ST_FT_PRIV = 6;
    localparam int ST_FT_SE   = 7;
    localparam int ST_FT_NFO  = 8;
    localparam int ST_NF      = 9;

    // Slot attributes, valid in bit 0.
    typedef struct packed {
        logic       nfo;
        logic       side_eff;
        logic       writable;
        logic       priv;
        logic [1:0] size;
        logic       global;
        logic       valid;
    } attr_t;

endpackage

// File: rtl/vtlb_entry_store.sv
// Slot storage: tag, context, physical page, attributes and used flag.
// Assumes a fill and a used-flag update to the same slot never both apply;
// the fill takes priority and clears the used flag.
module vtlb_entry_store
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 51,
    parameter int PPN_W   = 28,
    parameter int CTX_W   = 13,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [CTX_W-1:0] fill_ctx,
    input  logic [PPN_W-1:0] fill_ppn,
    input  attr_t            fill_attr,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [VPN_W-1:0] ent_vpn  [ENTRIES],
    output logic [CTX_W-1:0] ent_ctx  [ENTRIES],
    output logic [PPN_W-1:0] ent_ppn  [ENTRIES],
    output attr_t            ent_attr [ENTRIES],
    output logic [ENTRIES-1:0] used_flags
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic [VPN_W-1:0] vpn_q;
        logic [CTX_W-1:0] ctx_q;
        logic [PPN_W-1:0] ppn_q;
        attr_t            attr_q;
        logic             used_q;

        // Write the slot on fill, mark it used on a clean hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_q  <= '0;
                ctx_q  <= '0;
                ppn_q  <= '0;
                attr_q <= '0;
                used_q <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(e)) begin
                vpn_q  <= fill_vpn;
                ctx_q  <= fill_ctx;
                ppn_q  <= fill_ppn;
                attr_q <= fill_attr;
                used_q <= 1'b0;
            end else if (touch_en && touch_idx == IDX_W'(e)) begin
                used_q <= 1'b1;
            end
        end

        assign ent_vpn[e]    = vpn_q;
        assign ent_ctx[e]    = ctx_q;
        assign ent_ppn[e]    = ppn_q;
        assign ent_attr[e]   = attr_q;
        assign used_flags[e] = used_q;
    end

endmodule

// File: rtl/vtlb_match.sv
// Parallel compare of all slots under a per-slot size mask, with the
// lowest matching index selected. Assumes PPN_W <= VPN_W and that the
// largest page (3*3 low bits) fits inside PPN_W.
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int VPN_W     = 51,
    parameter int PPN_W     = 28,
    parameter int CTX_W     = 13,
    parameter int IDX_W     = 6,
    parameter int SIZE_STEP = 3
) (
    input  logic [VPN_W-1:0] look_vpn,
    input  logic [CTX_W-1:0] look_ctx,
    input  logic [VPN_W-1:0] ent_vpn  [ENTRIES],
    input  logic [CTX_W-1:0] ent_ctx  [ENTRIES],
    input  logic [PPN_W-1:0] ent_ppn  [ENTRIES],
    input  attr_t            ent_attr [ENTRIES],
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PPN_W-1:0] hit_ppn,
    output attr_t            hit_attr
);

    logic [ENTRIES-1:0] match_vec;
    logic [PPN_W-1:0]   xl_ppn [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [VPN_W-1:0] low_mask;
        logic             ctx_ok;
        logic             tag_ok;

        assign low_mask  = (VPN_W'(1) << (SIZE_STEP * int'(ent_attr[e].size))) - VPN_W'(1);
        assign ctx_ok    = ent_attr[e].global || (ent_ctx[e] == look_ctx);
        assign tag_ok    = ((ent_vpn[e] ^ look_vpn) & ~low_mask) == '0;
        assign match_vec[e] = ent_attr[e].valid && ctx_ok && tag_ok;
        assign xl_ppn[e] = (ent_ppn[e] & ~low_mask[PPN_W-1:0])
                         | (look_vpn[PPN_W-1:0] & low_mask[PPN_W-1:0]);
    end

    // Pick the lowest-index matching slot.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match_vec[e]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(e);
            end
        end
    end

    assign hit_ppn  = xl_ppn[hit_idx];
    assign hit_attr = ent_attr[hit_idx];

endmodule

// File: rtl/vtlb_access_check.sv
// Chooses the lookup context from the access class and judges the hit
// slot's attributes into a trap code, fault-type bits and permissions.
// Assumes req_space value 3 is treated as nucleus.
module vtlb_access_check
    import vtlb_pkg::*;
#(
    parameter int CTX_W = 13
) (
    input  logic             req_fetch,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_space,
    input  logic             req_user,
    input  logic             tl_zero,
    input  logic [CTX_W-1:0] ctx_primary,
    input  logic [CTX_W-1:0] ctx_secondary,
    input  logic             hit,
    input  attr_t            hit_attr,
    output logic [CTX_W-1:0] look_ctx,
    output logic [1:0]       ctx_class,
    output trap_e            trap,
    output logic [2:0]       ft_bits,
    output logic [2:0]       perm
);

    // Select the context and its class from fetch/data space.
    always_comb begin
        if (req_fetch) begin
            look_ctx  = tl_zero ? ctx_primary : '0;
            ctx_class = tl_zero ? SPACE_PRI : SPACE_NUC;
        end else begin
            case (req_space)
                SPACE_PRI: begin look_ctx = ctx_primary;   ctx_class = SPACE_PRI; end
                SPACE_SEC: begin look_ctx = ctx_secondary; ctx_class = SPACE_SEC; end
                default:   begin look_ctx = '0;            ctx_class = SPACE_NUC; end
            endcase
        end
    end

    // Judge permissions of the hit slot.
    always_comb begin
        trap    = TRAP_NONE;
        ft_bits = '0;
        perm    = '0;
        if (!hit) begin
            trap = req_fetch ? TRAP_IMISS : TRAP_DMISS;
        end else if (req_fetch) begin
            ft_bits[0] = hit_attr.priv && req_user;
            if (ft_bits[0]) trap = TRAP_IFAULT;
            else            perm = 3'b100;
        end else begin
            ft_bits[0] = hit_attr.priv && req_user;
            ft_bits[1] = (req_op == OP_NOFAULT) && hit_attr.side_eff;
            ft_bits[2] = (req_op != OP_NOFAULT) && hit_attr.nfo;
            if (|ft_bits)
                trap = TRAP_DFAULT;
            else if (req_op == OP_STORE && !hit_attr.writable)
                trap = TRAP_DPROT;
            else
                perm = {1'b0, hit_attr.writable, 1'b1};
        end
    end

endmodule

// File: rtl/vtlb_lookup.sv
// Top of the variable page size TLB lookup: slot store, parallel match,
// access check, registered response and the translation-state registers.
// Assumes page offset bits of req_va are ignored and results are due one
// edge after the request.
module vtlb_lookup
    import vtlb_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int VA_W       = 64,
    parameter int PA_W       = 41,
    parameter int CTX_W      = 13,
    parameter int PAGE_SHIFT = 13,
    parameter int SIZE_STEP  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fill_en,
    input  logic [$clog2(ENTRIES)-1:0]    fill_idx,
    input  logic [VA_W-PAGE_SHIFT-1:0]    fill_vpn,
    input  logic [CTX_W-1:0]              fill_ctx,
    input  logic [PA_W-PAGE_SHIFT-1:0]    fill_ppn,
    input  logic [7:0]                    fill_attr,
    input  logic                          req_valid,
    input  logic                          req_fetch,
    input  logic [1:0]                    req_op,
    input  logic [1:0]                    req_space,
    input  logic                          req_user,
    input  logic                          cpu_priv,
    input  logic                          tl_zero,
    input  logic [CTX_W-1:0]              ctx_primary,
    input  logic [CTX_W-1:0]              ctx_secondary,
    input  logic [VA_W-1:0]               req_va,
    input  logic                          d_status_clr,
    input  logic                          i_status_clr,
    output logic                          rsp_valid,
    output logic [2:0]                    rsp_trap,
    output logic [PA_W-PAGE_SHIFT-1:0]    rsp_ppn,
    output logic [2:0]                    rsp_perm,
    output logic [ENTRIES-1:0]            used_flags,
    output logic [9:0]                    d_status,
    output logic [VA_W-1:0]               d_fault_va,
    output logic [VA_W-1:0]               d_tag_access,
    output logic [9:0]                    i_status,
    output logic [VA_W-1:0]               i_tag_access
);

    localparam int VPN_W = VA_W - PAGE_SHIFT;
    localparam int PPN_W = PA_W - PAGE_SHIFT;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0] ent_vpn  [ENTRIES];
    logic [CTX_W-1:0] ent_ctx  [ENTRIES];
    logic [PPN_W-1:0] ent_ppn  [ENTRIES];
    attr_t            ent_attr [ENTRIES];

    logic [VPN_W-1:0] look_vpn;
    logic [CTX_W-1:0] look_ctx;
    logic [1:0]       ctx_class;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [PPN_W-1:0] hit_ppn;
    attr_t            hit_attr;
    trap_e            trap;
    logic [2:0]       ft_bits;
    logic [2:0]       perm;
    logic             touch_en;
    logic [VA_W-1:0]  tag_word;
    logic [VA_W-1:0]  page_va;
    logic [STATUS_W-1:0] d_new;
    logic [STATUS_W-1:0] i_new;

    assign look_vpn = req_va[VA_W-1:PAGE_SHIFT];
    assign touch_en = req_valid && (trap == TRAP_NONE);
    assign tag_word = {look_vpn, PAGE_SHIFT'(look_ctx)};
    assign page_va  = {look_vpn, {PAGE_SHIFT{1'b0}}};

    vtlb_entry_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .CTX_W(CTX_W), .IDX_W(IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_vpn  (fill_vpn),
        .fill_ctx  (fill_ctx),
        .fill_ppn  (fill_ppn),
        .fill_attr (attr_t'(fill_attr)),
        .touch_en  (touch_en),
        .touch_idx (hit_idx),
        .ent_vpn   (ent_vpn),
        .ent_ctx   (ent_ctx),
        .ent_ppn   (ent_ppn),
        .ent_attr  (ent_attr),
        .used_flags(used_flags)
    );

    vtlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .CTX_W(CTX_W), .IDX_W(IDX_W), .SIZE_STEP(SIZE_STEP)
    ) u_match (
        .look_vpn(look_vpn),
        .look_ctx(look_ctx),
        .ent_vpn (ent_vpn),
        .ent_ctx (ent_ctx),
        .ent_ppn (ent_ppn),
        .ent_attr(ent_attr),
        .hit     (hit),
        .hit_idx (hit_idx),
        .hit_ppn (hit_ppn),
        .hit_attr(hit_attr)
    );

    vtlb_access_check #(.CTX_W(CTX_W)) u_check (
        .req_fetch    (req_fetch),
        .req_op       (req_op),
        .req_space    (req_space),
        .req_user     (req_user),
        .tl_zero      (tl_zero),
        .ctx_primary  (ctx_primary),
        .ctx_secondary(ctx_secondary),
        .hit          (hit),
        .hit_attr     (hit_attr),
        .look_ctx     (look_ctx),
        .ctx_class    (ctx_class),
        .trap         (trap),
        .ft_bits      (ft_bits),
        .perm         (perm)
    );

    // Build the status words a fault would record this cycle.
    always_comb begin
        d_new                      = '0;
        d_new[ST_VALID]            = 1'b1;
        d_new[ST_OVF]              = d_status[ST_VALID] && !d_status_clr;
        d_new[ST_WRITE]            = (req_op == OP_STORE);
        d_new[ST_PRIV]             = cpu_priv;
        d_new[ST_CTX_LO +: 2]      = ctx_class;
        d_new[ST_FT_PRIV]          = ft_bits[0];
        d_new[ST_FT_SE]            = ft_bits[1];
        d_new[ST_FT_NFO]           = ft_bits[2];
        d_new[ST_NF]               = (req_op == OP_NOFAULT);
        i_new                      = '0;
        i_new[ST_VALID]            = 1'b1;
        i_new[ST_OVF]              = i_status[ST_VALID] && !i_status_clr;
        i_new[ST_PRIV]             = cpu_priv;
        i_new[ST_CTX_LO +: 2]      = ctx_class;
        i_new[ST_FT_PRIV]          = ft_bits[0];
    end

    // Register the lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= '0;
            rsp_ppn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_trap  <= req_valid ? trap : TRAP_NONE;
            rsp_ppn   <= touch_en ? hit_ppn : '0;
            rsp_perm  <= touch_en ? perm : '0;
        end
    end

    // Update the data-side status, fault address and tag-access registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_status     <= '0;
            d_fault_va   <= '0;
            d_tag_access <= '0;
        end else begin
            if (d_status_clr) d_status <= '0;
            if (req_valid && (trap == TRAP_DFAULT || trap == TRAP_DPROT)) begin
                d_status     <= d_new;
                d_fault_va   <= page_va;
                d_tag_access <= tag_word;
            end else if (req_valid && trap == TRAP_DMISS) begin
                d_tag_access <= tag_word;
            end
        end
    end

    // Update the fetch-side status and tag-access registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_status     <= '0;
            i_tag_access <= '0;
        end else begin
            if (i_status_clr) i_status <= '0;
            if (req_valid && trap == TRAP_IFAULT) begin
                i_status     <= i_new;
                i_tag_access <= tag_word;
            end else if (req_valid && trap == TRAP_IMISS) begin
                i_tag_access <= tag_word;
            end
        end
    end

endmodule

// File: rtl/vtlb_lookup_chk.sv
// Property checker for vtlb_lookup, attached with the bind below.
// Assumes reset is held for at least two edges.
module vtlb_lookup_chk #(
    parameter int VA_W  = 64,
    parameter int PPN_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             d_status_clr,
    input logic             rsp_valid,
    input logic [2:0]       rsp_trap,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic [2:0]       rsp_perm,
    input logic [9:0]       d_status,
    input logic [VA_W-1:0]  d_fault_va
);

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r9_trap_gives_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap != 3'd0) |-> (rsp_perm == 3'd0 && rsp_ppn == '0));

    a_r10_hit_grants_access: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap == 3'd0) |-> (rsp_perm == 3'b100 || rsp_perm[0]));

    a_r11_exec_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_perm[2] |-> (rsp_perm[1:0] == 2'b00));

    a_r8_overflow_needs_prior: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_status[1]) |-> $past(d_status[0]));

    a_r8_fault_va_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(d_fault_va) |-> (rsp_valid && (rsp_trap == 3'd3 || rsp_trap == 3'd4)));

    a_r9_miss_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap == 3'd1 && !$past(d_status_clr)) |-> $stable(d_status));

endmodule

bind vtlb_lookup vtlb_lookup_chk #(
    .VA_W (VA_W),
    .PPN_W(PA_W - PAGE_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .d_status_clr(d_status_clr),
    .rsp_valid   (rsp_valid),
    .rsp_trap    (rsp_trap),
    .rsp_ppn     (rsp_ppn),
    .rsp_perm    (rsp_perm),
    .d_status    (d_status),
    .d_fault_va  (d_fault_va)
);

// File: tb/sim_vtlb_lookup.sv
`timescale 1ns/1ps
module sim_vtlb_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_en = 1'b0;
    logic [5:0]  fill_idx = '0;
    logic [50:0] fill_vpn = '0;
    logic [12:0] fill_ctx = '0;
    logic [27:0] fill_ppn = '0;
    logic [7:0]  fill_attr = '0;
    logic        req_valid = 1'b0;
    logic        req_fetch = 1'b0;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_space = '0;
    logic        req_user = 1'b0;
    logic        cpu_priv = 1'b0;
    logic        tl_zero = 1'b1;
    logic [12:0] ctx_primary = 13'd5;
    logic [12:0] ctx_secondary = 13'd9;
    logic [63:0] req_va = '0;
    logic        d_status_clr = 1'b0;
    logic        i_status_clr = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_trap;
    logic [27:0] rsp_ppn;
    logic [2:0]  rsp_perm;
    logic [63:0] used_flags;
    logic [9:0]  d_status;
    logic [63:0] d_fault_va;
    logic [63:0] d_tag_access;
    logic [9:0]  i_status;
    logic [63:0] i_tag_access;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vtlb_lookup u0 (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .fill_ctx(fill_ctx), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
        .req_valid(req_valid), .req_fetch(req_fetch), .req_op(req_op),
        .req_space(req_space), .req_user(req_user), .cpu_priv(cpu_priv),
        .tl_zero(tl_zero), .ctx_primary(ctx_primary), .ctx_secondary(ctx_secondary),
        .req_va(req_va), .d_status_clr(d_status_clr), .i_status_clr(i_status_clr),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_ppn(rsp_ppn),
        .rsp_perm(rsp_perm), .used_flags(used_flags), .d_status(d_status),
        .d_fault_va(d_fault_va), .d_tag_access(d_tag_access),
        .i_status(i_status), .i_tag_access(i_tag_access)
    );

    typedef struct packed {
        logic        fetch;
        logic [1:0]  op;
        logic [1:0]  space;
        logic        user;
        logic        priv;
        logic [50:0] vpn;
        logic [2:0]  trap;
        logic [27:0] ppn;
        logic [2:0]  perm;
    } vec_t;

    // fetch, op, space, user, priv, vpn, trap, ppn, perm
    localparam vec_t VECS [15] = '{
        '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h1000,  3'd0, 28'hABC,   3'd3},
        '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h401A5, 3'd0, 28'h121A5, 3'd1},
        '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 51'h401A5, 3'd4, 28'h0,     3'd0},
        '{1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 51'h602B,  3'd0, 28'h66B,   3'd3},
        '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h602B,  3'd1, 28'h0,     3'd0},
        '{1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 51'h3000,  3'd3, 28'h0,     3'd0},
        '{1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 51'h3000,  3'd0, 28'h777,   3'd3},
        '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h2005,  3'd3, 28'h0,     3'd0},
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 51'h2005,  3'd0, 28'h305,   3'd3},
        '{1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 51'h2005,  3'd3, 28'h0,     3'd0},
        '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h5000,  3'd0, 28'h111,   3'd3},
        '{1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 51'h7000,  3'd1, 28'h0,     3'd0},
        '{1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 51'h1000,  3'd0, 28'hABC,   3'd4},
        '{1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 51'h2005,  3'd5, 28'h0,     3'd0},
        '{1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 51'h2005,  3'd0, 28'h305,   3'd4}
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic fill(input int idx, input logic [50:0] vpn, input logic [12:0] ctx,
                        input logic [27:0] ppn, input logic [7:0] attr);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 6'(idx); fill_vpn = vpn;
        fill_ctx = ctx; fill_ppn = ppn; fill_attr = attr;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic lookup(input logic fetch, input logic [1:0] op, input logic [1:0] space,
                          input logic user, input logic priv, input logic [50:0] vpn);
        @(negedge clk);
        req_valid = 1'b1; req_fetch = fetch; req_op = op; req_space = space;
        req_user = user; cpu_priv = priv; req_va = {vpn, 13'h0};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_status(input logic dside);
        @(negedge clk);
        if (dside) d_status_clr = 1'b1; else i_status_clr = 1'b1;
        @(negedge clk);
        d_status_clr = 1'b0; i_status_clr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 reset used", used_flags, 64'd0);
        check("R1 reset d_status", 64'(d_status), 64'd0);
        check("R1 reset i_status", 64'(i_status), 64'd0);
        check("R1 reset d_tag", d_tag_access, 64'd0);

        fill(0, 51'h1000,  13'd5, 28'hABC,   8'h21);
        fill(1, 51'h40000, 13'd3, 28'h12000, 8'h0F);
        fill(2, 51'h2000,  13'd5, 28'h300,   8'h75);
        fill(3, 51'h3000,  13'd0, 28'h777,   8'hA1);
        fill(4, 51'h5000,  13'd1, 28'h111,   8'h23);
        fill(5, 51'h5000,  13'd1, 28'h222,   8'h23);
        fill(6, 51'h6000,  13'd9, 28'h640,   8'h29);
        fill(7, 51'h7000,  13'd5, 28'h700,   8'h20);

        // R2 R3 R4 R5 R6 R7 R9 R10 R11: table walk
        for (int i = 0; i < 15; i++) begin
            lookup(VECS[i].fetch, VECS[i].op, VECS[i].space, VECS[i].user,
                   VECS[i].priv, VECS[i].vpn);
            check($sformatf("R1 vec%0d valid", i), 64'(rsp_valid), 64'd1);
            check($sformatf("R2-trap vec%0d", i), 64'(rsp_trap), 64'(VECS[i].trap));
            check($sformatf("R2-ppn vec%0d", i), 64'(rsp_ppn), 64'(VECS[i].ppn));
            check($sformatf("R10-perm vec%0d", i), 64'(rsp_perm), 64'(VECS[i].perm));
        end
        @(negedge clk);
        check("R1 idle rsp_valid", 64'(rsp_valid), 64'd0);
        // R10: used flags set by clean hits only; R4: slot 5 never used
        check("R10 used mask", used_flags, 64'h5F);
        // R11: fetch fault status recorded
        check("R11 i_status", 64'(i_status), 64'h041);
        check("R11 i_tag", i_tag_access, {51'h2005, 13'd5});

        // R12: refill clears used, faulting access does not set it
        fill(2, 51'h2000, 13'd5, 28'h300, 8'h75);
        check("R12 refill clears used", used_flags, 64'h5B);
        lookup(1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h2005);
        check("R10 fault leaves used", used_flags, 64'h5B);

        // R12 R7 R8: clear then protection fault
        clear_status(1'b1);
        check("R12 d_status cleared", 64'(d_status), 64'd0);
        lookup(1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 51'h401A5);
        check("R7 trap", 64'(rsp_trap), 64'd4);
        check("R8 d_status prot", 64'(d_status), 64'h00D);
        check("R8 d_fault_va", d_fault_va, {51'h401A5, 13'h0});
        check("R8 d_tag", d_tag_access, {51'h401A5, 13'd5});
        // R6 R8: second fault without clear sets overflow
        lookup(1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h2005);
        check("R8 overflow status", 64'(d_status), 64'h043);
        check("R8 d_fault_va 2", d_fault_va, {51'h2005, 13'h0});

        // R9: secondary miss updates only tag access
        lookup(1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 51'h9000);
        check("R9 miss trap", 64'(rsp_trap), 64'd1);
        check("R9 miss tag", d_tag_access, {51'h9000, 13'd9});
        check("R9 miss status kept", 64'(d_status), 64'h043);
        check("R9 miss fva kept", d_fault_va, {51'h2005, 13'h0});

        // R6: no-fault load to side-effect page
        clear_status(1'b1);
        lookup(1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 51'h2005);
        check("R6 side effect status", 64'(d_status), 64'h289);
        // R5 R6: nucleus class and no-fault-only page
        clear_status(1'b1);
        lookup(1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 51'h3000);
        check("R6 nfo status", 64'(d_status), 64'h129);
        check("R5 nucleus tag", d_tag_access, {51'h3000, 13'd0});

        // R5: fetch above trap level zero uses context zero
        tl_zero = 1'b0;
        lookup(1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 51'h1000);
        check("R5 fetch tl miss", 64'(rsp_trap), 64'd2);
        check("R5 fetch tl tag", i_tag_access, {51'h1000, 13'd0});
        tl_zero = 1'b1;

        // R11: second fetch fault sets overflow; R12 clear
        lookup(1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 51'h2005);
        check("R11 i overflow", 64'(i_status), 64'h043);
        clear_status(1'b0);
        check("R12 i_status cleared", 64'(i_status), 64'd0);

        // R4: remove slot 4, slot 5 now answers
        fill(4, 51'h5000, 13'd1, 28'h111, 8'h22);
        lookup(1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 51'h5000);
        check("R4 next slot ppn", 64'(rsp_ppn), 64'h222);
        // R3: context mismatch on a non-global slot misses
        lookup(1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 51'h1000);
        check("R3 ctx mismatch", 64'(rsp_trap), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule